// File: doc/BRIEF.md
# PS/2 Port Register Front End

This block gives a processor a small register window for one PS/2 keyboard or mouse port. The processor talks to it over a simple 32-bit register bus with separate read and write strobes. The block holds a control word, a stored clock divisor, a status view, a data port and an interrupt view. The top of the 4 KB window holds a read-only identification area. The serial framing on the PS/2 wires lives in a neighbouring block. This block only exchanges whole bytes with it: it takes received bytes through a valid/ready stream and sends outgoing bytes as one-cycle valid pulses.

A received byte sits in a one-byte holding stage until software reads the data port. That read moves the byte into a latched copy, which later data reads return again. The status parity flag is the XOR of all bits of this latched copy. The interrupt output is built combinationally from two parts. One is the waiting byte, gated by a receive-enable control bit. The other is a force bit in the control word, which raises the line unconditionally.

Top module: `ps2_regif`

## Requirements
- R1: After reset the control and divisor registers read 0, no byte is waiting, `rx_ready` is 1, `irq` is 0 and `tx_valid` is 0.
- R2: Reads have one cycle of latency: `bus_rdata` holds the selected value from the cycle after the read strobe. The control word (offset 0x00) and the divisor (offset 0x0C) store all 32 written bits and read them back unchanged.
- R3: The status word (offset 0x04) has these bits: bit 6 is always 1, bit 4 is 1 while a byte is waiting, and bit 2 is the XOR of all eight bits of the latched data byte. Every other bit reads 0.
- R4: A data read (offset 0x08) while a byte is waiting returns that byte in bits 7:0 with zeros above. The read latches the byte, clears the waiting flag and raises `rx_ready` again.
- R5: A data read with no byte waiting returns the previously latched byte and changes nothing.
- R6: While a byte is waiting, `rx_ready` is 0 and further `rx_valid` bytes are ignored, so the held byte is left as it was.
- R7: `irq` equals (byte waiting AND control bit 4) OR control bit 3. It follows a control write in the cycle after the write strobe.
- R8: The interrupt-status word (offset 0x10) reads the waiting flag in bit 0 and 1 in bit 1, with zeros above.
- R9: A data write pulses `tx_valid` for exactly one cycle, in the cycle after the write strobe, with `tx_data` equal to write bits 7:0. No other access pulses it.
- R10: Reads from 0xFE0 through 0xFFC return one byte per word, in this order: 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Reads of unmapped offsets return 0. Writes to status, interrupt status, the ID area and unmapped offsets change no register and send no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address within the window; bits 1:0 are ignored |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Holding stage empty |
| tx_valid | output | 1 | One-cycle pulse for an outgoing byte |
| tx_data | output | 8 | Outgoing byte |

## Verification
A stuck or wrongly set waiting flag shows up on the ports at once. `rx_ready` and `irq` follow it in the same cycle, and the next status or interrupt-status read shows the wrong bits 4 and 0. A corrupted holding or latched byte shows up only on the next data read, or through the parity bit on the next status read. The bench therefore alternates data reads with status reads. Decode faults appear as a wrong `bus_rdata` one cycle after the strobe, or as a stray `tx_valid` pulse.

// File: rtl/ps2_regif_pkg.sv
package ps2_regif_pkg;

    // word indices inside the register window
    localparam int OFF_CTRL   = 0;
    localparam int OFF_STAT   = 1;
    localparam int OFF_DATA   = 2;
    localparam int OFF_CLKDIV = 3;
    localparam int OFF_INTST  = 4;

    // status bit positions
    localparam int ST_TX_EMPTY = 6;
    localparam int ST_RX_FULL  = 4;
    localparam int ST_PARITY   = 2;

    // control bit positions
    localparam int CTRL_RX_IE = 4;
    localparam int CTRL_FORCE = 3;

    // interrupt-status bit positions
    localparam int IS_PENDING = 0;
    localparam int IS_FIXED   = 1;

    localparam int ID_COUNT = 8;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] v;
        case (idx)
            3'd0: v = 8'h50;
            3'd1: v = 8'h10;
            3'd2: v = 8'h04;
            3'd3: v = 8'h00;
            3'd4: v = 8'h0D;
            3'd5: v = 8'hF0;
            3'd6: v = 8'h05;
            default: v = 8'hB1;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ps2_rx_hold.sv
module ps2_rx_hold #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              consume,
    output logic              rx_ready,
    output logic              pending,
    output logic [BYTE_W-1:0] hold_byte,
    output logic [BYTE_W-1:0] last_byte
);

    typedef struct packed {
        logic              pend;
        logic [BYTE_W-1:0] hold;
        logic [BYTE_W-1:0] last;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.pend) begin
            if (consume) begin
                st_d.last = st_q.hold;
                st_d.pend = 1'b0;
            end
        end else if (rx_valid) begin
            st_d.hold = rx_data;
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_ready  = !st_q.pend;
    assign pending   = st_q.pend;
    assign hold_byte = st_q.hold;
    assign last_byte = st_q.last;

endmodule

// File: rtl/ps2_parity.sv
module ps2_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    output logic         odd
);

    logic [W-1:0] acc;

    assign acc[0] = din[0];
    for (genvar i = 1; i < W; i++) begin : g_chain
        assign acc[i] = acc[i-1] ^ din[i];
    end

    assign odd = acc[W-1];

endmodule

// File: rtl/ps2_irq_gen.sv
module ps2_irq_gen (
    input  logic pending,
    input  logic rx_ie,
    input  logic force_on,
    output logic irq
);

    assign irq = (pending && rx_ie) || force_on;

endmodule

// File: rtl/ps2_regif.sv
module ps2_regif
    import ps2_regif_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data
);

    localparam int WORD_W = ADDR_W - 2;
    localparam int ID_LSB = 5;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] clkdiv;
        logic [DATA_W-1:0] rdata;
        logic              txv;
        logic [BYTE_W-1:0] txd;
    } regs_t;

    regs_t st_d, st_q;

    logic [WORD_W-1:0] word;
    logic              id_hit;
    logic              sel_ctrl, sel_stat, sel_data, sel_clkdiv, sel_intst;
    logic              consume;
    logic              pending;
    logic [BYTE_W-1:0] hold_byte, last_byte;
    logic              par_odd;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] ctrl_q;
    logic              unused_lo;

    assign unused_lo = ^bus_addr[1:0];
    assign word      = bus_addr[ADDR_W-1:2];
    assign id_hit    = &bus_addr[ADDR_W-1:ID_LSB];

    assign sel_ctrl   = !id_hit && (word == WORD_W'(OFF_CTRL));
    assign sel_stat   = !id_hit && (word == WORD_W'(OFF_STAT));
    assign sel_data   = !id_hit && (word == WORD_W'(OFF_DATA));
    assign sel_clkdiv = !id_hit && (word == WORD_W'(OFF_CLKDIV));
    assign sel_intst  = !id_hit && (word == WORD_W'(OFF_INTST));

    assign consume = bus_rd && sel_data && pending;

    ps2_rx_hold #(.BYTE_W(BYTE_W)) rx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .consume   (consume),
        .rx_ready  (rx_ready),
        .pending   (pending),
        .hold_byte (hold_byte),
        .last_byte (last_byte)
    );

    ps2_parity #(.W(BYTE_W)) par_i (
        .din (last_byte),
        .odd (par_odd)
    );

    ps2_irq_gen irq_i (
        .pending  (pending),
        .rx_ie    (st_q.ctrl[CTRL_RX_IE]),
        .force_on (st_q.ctrl[CTRL_FORCE]),
        .irq      (irq)
    );

    // read value selection
    always_comb begin
        rd_mux = '0;
        if (id_hit) begin
            rd_mux[7:0] = id_byte(bus_addr[4:2]);
        end else if (sel_ctrl) begin
            rd_mux = st_q.ctrl;
        end else if (sel_stat) begin
            rd_mux[ST_TX_EMPTY] = 1'b1;
            rd_mux[ST_RX_FULL]  = pending;
            rd_mux[ST_PARITY]   = par_odd;
        end else if (sel_data) begin
            rd_mux[BYTE_W-1:0] = pending ? hold_byte : last_byte;
        end else if (sel_clkdiv) begin
            rd_mux = st_q.clkdiv;
        end else if (sel_intst) begin
            rd_mux[IS_PENDING] = pending;
            rd_mux[IS_FIXED]   = 1'b1;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.txv = 1'b0;
        if (bus_wr) begin
            if (sel_ctrl)   st_d.ctrl   = bus_wdata;
            if (sel_clkdiv) st_d.clkdiv = bus_wdata;
            if (sel_data) begin
                st_d.txv = 1'b1;
                st_d.txd = bus_wdata[BYTE_W-1:0];
            end
        end
        if (bus_rd) st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;
    assign tx_valid  = st_q.txv;
    assign tx_data   = st_q.txd;
    assign ctrl_q    = st_q.ctrl;

endmodule

// File: rtl/ps2_regif_chk.sv
module ps2_regif_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [BYTE_W-1:0] tx_data,
    input logic [DATA_W-1:0] ctrl_q
);

    logic in_id, is_stat, is_data, is_int;
    assign in_id   = &bus_addr[ADDR_W-1:5];
    assign is_stat = !in_id && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));
    assign is_data = !in_id && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(2));
    assign is_int  = !in_id && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(4));

    assert_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((!rx_ready && ctrl_q[4]) || ctrl_q[3]));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> !rx_ready);

    assert_consume_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && is_data && !rx_ready) |=> rx_ready);

    assert_tx_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_data) |=> (tx_valid && tx_data == $past(bus_wdata[BYTE_W-1:0])));

    assert_tx_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && is_data) |=> !tx_valid);

    assert_intst_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && is_int) |=> (bus_rdata[1] && bus_rdata[DATA_W-1:2] == '0
                                && bus_rdata[0] == $past(!rx_ready)));

    assert_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && is_stat) |=> (bus_rdata[6] && bus_rdata[4] == $past(!rx_ready)));

endmodule

bind ps2_regif ps2_regif_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .ctrl_q    (ctrl_q)
);

// File: tb/ps2_regif_tb_top.sv
module ps2_regif_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ps2_regif dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 rx_ready", {31'd0, rx_ready}, 32'd1);
        check("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
        bus_read(12'h000, v); check("R1 ctrl", v, 32'd0);
        bus_read(12'h00C, v); check("R1 clkdiv", v, 32'd0);
        bus_read(12'h004, v); check("R3 status after reset", v, 32'h40);
        bus_read(12'h010, v); check("R8 intstat idle", v, 32'h2);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        bus_write(12'h000, 32'h1234_5600); bus_read(12'h000, v);
        check("R2 ctrl readback", v, 32'h1234_5600);
        bus_write(12'h00C, 32'hDEAD_BEEF); bus_read(12'h00C, v);
        check("R2 clkdiv readback", v, 32'hDEAD_BEEF);
        bus_write(12'h000, 32'h0);
    endtask

    task automatic t_receive();
        logic [31:0] v;
        bus_write(12'h000, 32'h10);
        check("R7 enabled, nothing waiting", {31'd0, irq}, 32'd0);
        send_byte(8'h07);
        check("R7 irq on waiting byte", {31'd0, irq}, 32'd1);
        check("R6 ready low", {31'd0, rx_ready}, 32'd0);
        bus_read(12'h004, v); check("R3 status rx full", v, 32'h50);
        bus_read(12'h010, v); check("R8 intstat waiting", v, 32'h3);
        send_byte(8'h99);
        check("R6 second byte refused", {31'd0, rx_ready}, 32'd0);
        bus_read(12'h008, v); check("R4 data read", v, 32'h07);
        check("R4 ready again", {31'd0, rx_ready}, 32'd1);
        check("R7 irq drops", {31'd0, irq}, 32'd0);
        bus_read(12'h004, v); check("R3 parity odd", v, 32'h44);
        bus_read(12'h008, v); check("R5 repeat read", v, 32'h07);
        bus_write(12'h000, 32'h0);
        send_byte(8'hA5);
        check("R7 gated off", {31'd0, irq}, 32'd0);
        bus_read(12'h008, v); check("R4 second byte", v, 32'hA5);
        bus_read(12'h004, v); check("R3 parity even", v, 32'h40);
    endtask

    task automatic t_force();
        bus_write(12'h000, 32'h08);
        check("R7 force bit", {31'd0, irq}, 32'd1);
        bus_write(12'h000, 32'h00);
        check("R7 force cleared", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_transmit();
        @(negedge clk);
        bus_addr = 12'h008; bus_wdata = 32'h0000_01AB; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R9 tx_valid pulse", {31'd0, tx_valid}, 32'd1);
        check("R9 tx_data", {24'd0, tx_data}, 32'hAB);
        @(negedge clk);
        check("R9 pulse ends", {31'd0, tx_valid}, 32'd0);
    endtask

    task automatic t_id();
        logic [31:0] v;
        logic [7:0] exp_id [8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 8; i++) begin
            bus_read(12'hFE0 + 12'(i * 4), v);
            check("R10 id byte", v, {24'd0, exp_id[i]});
        end
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        bus_write(12'h000, 32'h0000_0020);
        bus_read(12'h014, v); check("R11 unmapped read", v, 32'd0);
        bus_read(12'h800, v); check("R11 unmapped far read", v, 32'd0);
        bus_write(12'h004, 32'hFFFF_FFFF);
        check("R11 no tx on status write", {31'd0, tx_valid}, 32'd0);
        bus_write(12'h010, 32'hFFFF_FFFF);
        bus_write(12'hFE0, 32'hFFFF_FFFF);
        bus_write(12'hFE8, 32'hFFFF_FFFF);
        check("R11 no tx on id write", {31'd0, tx_valid}, 32'd0);
        bus_write(12'h020, 32'hFFFF_FFFF);
        bus_read(12'h000, v); check("R11 ctrl kept", v, 32'h20);
        bus_read(12'h00C, v); check("R11 clkdiv kept", v, 32'hDEAD_BEEF);
        bus_read(12'h004, v); check("R11 status kept", v, 32'h40);
        bus_read(12'hFE0, v); check("R11 id kept", v, 32'h50);
        check("R11 irq kept low", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_receive();
        t_force();
        t_transmit();
        t_id();
        t_unmapped();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule